// File: doc/BRIEF.md
# Instruction Prefix Decoder

This block sits in the fetch and decode front end of an 8-bit processor. It takes the instruction byte stream one byte per accepted handshake. It recognises an optional leading prefix byte and qualifies the opcode that follows. For each opcode it reports four things: the final addressing mode, which index register applies, whether the access goes through a pointer, and the total number of bytes the instruction occupies. The fetch unit uses that length to advance its program counter.

The mode of every opcode before any prefix, and its operand byte count, come from an opcode classification table outside the block. That table presents them on the lookup inputs for the byte currently on the data input. Three prefix codes are recognised, and each rewrites the opcode's mode in its own way. The first switches the X register to Y. The second turns direct-style and X-indexed modes into their pointer-based forms. The third turns X-indexed into the pointer-based Y-indexed form. The operand bytes that follow an opcode are consumed and counted but not decoded, so an operand byte with a prefix value never acts as a prefix.

Top module: `prebyte_decoder`

## Requirements
- R1: While `rst` is high, `in_ready` and `dec_valid` are 0. After reset, the next accepted byte is taken as the first byte of an instruction, and any prefix pending when reset rose is dropped.
- R2: The mode codes are INH=0, IMM=1, DIR=2, DBIT=3, DREL=4, IDX=5, IND_DIR=6, IND_DBIT=7, IND_DREL=8, IND_IDX=9, and 10..15 other. An opcode with no prefix produces a `dec_valid` pulse in the cycle after it is accepted. With that pulse, `dec_mode` equals the base mode, `dec_idx_y`=0, `dec_indirect`=0, `dec_illegal`=0, `dec_len`=1+operand count, and `dec_opcode` holds the opcode byte.
- R3: Prefix 0x90 before a base mode of INH, IMM, DIR or IDX keeps the mode, sets `dec_idx_y`=1 and `dec_indirect`=0, and gives `dec_len`=2+operand count.
- R4: Prefix 0x92 maps DIR to IND_DIR, DBIT to IND_DBIT, DREL to IND_DREL and IDX to IND_IDX. It sets `dec_indirect`=1 and `dec_idx_y`=0, and gives `dec_len`=2+operand count.
- R5: Prefix 0x91 before base mode IDX gives IND_IDX with `dec_idx_y`=1, `dec_indirect`=1 and `dec_len`=2+operand count.
- R6: A prefix before a base mode it cannot rewrite sets `dec_illegal`=1. The decode then falls back to the unprefixed meaning (base mode, `dec_idx_y`=0, `dec_indirect`=0), and `dec_len` still counts the prefix (2+operand count).
- R7: Accepting a prefix byte produces no `dec_valid`. The byte that follows a prefix is always decoded as the opcode, even when its value is 0x90, 0x91 or 0x92.
- R8: After an opcode with operand count n, the next n accepted bytes are consumed without producing `dec_valid` and are never taken as a prefix. The byte after them starts a new instruction.
- R9: A prefix applies only to the opcode that immediately follows it. The next instruction without a prefix decodes with `dec_idx_y`=0 and `dec_indirect`=0.
- R10: A cycle in which no byte is accepted produces no `dec_valid` in the following cycle. A pending prefix and a pending operand count are held across any number of such idle cycles.
- R11: An operand count input of 3 is treated as 2, so `dec_len` never exceeds 4, and only two operand bytes are consumed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A fetched byte is offered on `in_data` |
| in_ready | output | 1 | Decoder accepts the offered byte this cycle |
| in_data | input | 8 | Instruction stream byte |
| lkp_mode | input | 4 | Base mode code of the byte on `in_data` |
| lkp_opnd | input | 2 | Base operand byte count of the byte on `in_data` |
| dec_valid | output | 1 | One-cycle pulse: decode fields below are new |
| dec_opcode | output | 8 | Opcode byte of the decoded instruction |
| dec_mode | output | 4 | Final addressing mode code |
| dec_idx_y | output | 1 | Index register select, 0 = X, 1 = Y |
| dec_indirect | output | 1 | Addressing goes through a memory pointer |
| dec_len | output | 3 | Total instruction length in bytes, prefix included |
| dec_illegal | output | 1 | Prefix not applicable to this opcode's base mode |

## Verification
On every cycle, the checker enforces several properties. Reset silences the decode output. A decode pulse only follows an accepted byte. An indirect result always carries one of the four pointer modes, and a Y-select without indirection only accompanies the four modes the Y prefix may rewrite. An illegal flag always comes with X and direct addressing, and the reported length stays within four bytes. The sequencing depends on the stream, and only the bench's scenarios show it. These scenarios cover operand bytes carrying prefix values, a prefix value used as the opcode, a prefix held through idle gaps, a prefix dropped by a mid-instruction reset, and the clamping of an oversized operand count.

// File: rtl/pbd_pkg.sv
package pbd_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MD_INH      = 4'd0,
    MD_IMM      = 4'd1,
    MD_DIR      = 4'd2,
    MD_DBIT     = 4'd3,
    MD_DREL     = 4'd4,
    MD_IDX      = 4'd5,
    MD_IND_DIR  = 4'd6,
    MD_IND_DBIT = 4'd7,
    MD_IND_DREL = 4'd8,
    MD_IND_IDX  = 4'd9,
    MD_OTHER    = 4'd10,
    MD_RSV11    = 4'd11,
    MD_RSV12    = 4'd12,
    MD_RSV13    = 4'd13,
    MD_RSV14    = 4'd14,
    MD_RSV15    = 4'd15
  } mode_t;

  typedef enum logic [1:0] {
    PK_NONE = 2'd0,
    PK_Y    = 2'd1,
    PK_IY   = 2'd2,
    PK_IND  = 2'd3
  } pfx_kind_t;

  typedef enum logic [1:0] {
    ST_FIRST = 2'd0,
    ST_OPC   = 2'd1,
    ST_OPND  = 2'd2
  } seq_st_t;

endpackage

// File: rtl/pbd_prefix_class.sv
module pbd_prefix_class
  import pbd_pkg::*;
#(
  parameter int                  DATA_W  = 8,
  parameter logic [DATA_W-1:0]   PFX_Y   = 8'h90,
  parameter logic [DATA_W-1:0]   PFX_IY  = 8'h91,
  parameter logic [DATA_W-1:0]   PFX_IND = 8'h92
) (
  input  logic [DATA_W-1:0] byte_in,
  output logic              is_pfx,
  output pfx_kind_t         kind
);

  localparam int NUM_PFX = 3;
  localparam logic [DATA_W-1:0] CODES [NUM_PFX] = '{PFX_Y, PFX_IY, PFX_IND};

  logic [NUM_PFX-1:0] hit;

  for (genvar g = 0; g < NUM_PFX; g++) begin : g_cmp
    assign hit[g] = (byte_in == CODES[g]);
  end

  assign is_pfx = |hit;

  always_comb begin
    kind = PK_NONE;
    if (hit[0])      kind = PK_Y;
    else if (hit[1]) kind = PK_IY;
    else if (hit[2]) kind = PK_IND;
  end

endmodule

// File: rtl/pbd_mode_rewrite.sv
module pbd_mode_rewrite
  import pbd_pkg::*;
#(
  parameter int OPND_W   = 2,
  parameter int MAX_OPND = 2,
  parameter int LEN_W    = 3
) (
  input  pfx_kind_t         kind,
  input  mode_t             base_mode,
  input  logic [OPND_W-1:0] opnd_in,
  output logic [OPND_W-1:0] opnd_eff,
  output mode_t             mode_out,
  output logic              idx_y,
  output logic              indirect,
  output logic              illegal,
  output logic [LEN_W-1:0]  len
);

  logic legal;
  logic has_pfx;

  assign opnd_eff = (int'(opnd_in) > MAX_OPND) ? OPND_W'(MAX_OPND) : opnd_in;
  assign has_pfx  = (kind != PK_NONE);

  always_comb begin
    legal    = 1'b1;
    mode_out = base_mode;
    idx_y    = 1'b0;
    indirect = 1'b0;
    unique case (kind)
      PK_NONE: ;
      PK_Y: begin
        if (base_mode inside {MD_INH, MD_IMM, MD_DIR, MD_IDX}) idx_y = 1'b1;
        else legal = 1'b0;
      end
      PK_IND: begin
        indirect = 1'b1;
        case (base_mode)
          MD_DIR:  mode_out = MD_IND_DIR;
          MD_DBIT: mode_out = MD_IND_DBIT;
          MD_DREL: mode_out = MD_IND_DREL;
          MD_IDX:  mode_out = MD_IND_IDX;
          default: begin
            legal    = 1'b0;
            indirect = 1'b0;
          end
        endcase
      end
      PK_IY: begin
        if (base_mode == MD_IDX) begin
          mode_out = MD_IND_IDX;
          idx_y    = 1'b1;
          indirect = 1'b1;
        end else begin
          legal = 1'b0;
        end
      end
      default: legal = 1'b0;
    endcase
    if (!legal) begin
      mode_out = base_mode;
      idx_y    = 1'b0;
      indirect = 1'b0;
    end
  end

  assign illegal = has_pfx && !legal;
  assign len     = LEN_W'(1) + LEN_W'(has_pfx) + LEN_W'(opnd_eff);

endmodule

// File: rtl/pbd_seq.sv
module pbd_seq
  import pbd_pkg::*;
#(
  parameter int OPND_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              is_pfx,
  input  pfx_kind_t         kind_in,
  input  logic [OPND_W-1:0] opnd_eff,
  output pfx_kind_t         cur_kind,
  output logic              opc_fire
);

  seq_st_t           state;
  pfx_kind_t         held;
  logic [OPND_W-1:0] left;

  assign cur_kind = (state == ST_OPC) ? held : PK_NONE;
  assign opc_fire = accept &&
                    ((state == ST_OPC) || ((state == ST_FIRST) && !is_pfx));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FIRST;
      held  <= PK_NONE;
      left  <= '0;
    end else if (accept) begin
      unique case (state)
        ST_FIRST: begin
          if (is_pfx) begin
            held  <= kind_in;
            state <= ST_OPC;
          end else if (opnd_eff != '0) begin
            left  <= opnd_eff;
            state <= ST_OPND;
          end
        end
        ST_OPC: begin
          held <= PK_NONE;
          if (opnd_eff != '0) begin
            left  <= opnd_eff;
            state <= ST_OPND;
          end else begin
            state <= ST_FIRST;
          end
        end
        ST_OPND: begin
          left <= left - 1'b1;
          if (left == OPND_W'(1)) state <= ST_FIRST;
        end
        default: state <= ST_FIRST;
      endcase
    end
  end

endmodule

// File: rtl/prebyte_decoder.sv
module prebyte_decoder
  import pbd_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                OPND_W   = 2,
  parameter int                MAX_OPND = 2,
  parameter logic [DATA_W-1:0] PFX_Y    = 8'h90,
  parameter logic [DATA_W-1:0] PFX_IY   = 8'h91,
  parameter logic [DATA_W-1:0] PFX_IND  = 8'h92,
  localparam int               LEN_W    = $clog2(MAX_OPND + 3)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [MODE_W-1:0] lkp_mode,
  input  logic [OPND_W-1:0] lkp_opnd,
  output logic              dec_valid,
  output logic [DATA_W-1:0] dec_opcode,
  output logic [MODE_W-1:0] dec_mode,
  output logic              dec_idx_y,
  output logic              dec_indirect,
  output logic [LEN_W-1:0]  dec_len,
  output logic              dec_illegal
);

  logic              accept;
  logic              is_pfx;
  pfx_kind_t         byte_kind;
  pfx_kind_t         cur_kind;
  logic              opc_fire;
  logic [OPND_W-1:0] opnd_eff;
  mode_t             r_mode;
  logic              r_y, r_ind, r_ill;
  logic [LEN_W-1:0]  r_len;

  assign accept = in_valid && in_ready;

  pbd_prefix_class #(
    .DATA_W(DATA_W), .PFX_Y(PFX_Y), .PFX_IY(PFX_IY), .PFX_IND(PFX_IND)
  ) u_class (
    .byte_in(in_data),
    .is_pfx (is_pfx),
    .kind   (byte_kind)
  );

  pbd_mode_rewrite #(
    .OPND_W(OPND_W), .MAX_OPND(MAX_OPND), .LEN_W(LEN_W)
  ) u_rewrite (
    .kind     (cur_kind),
    .base_mode(mode_t'(lkp_mode)),
    .opnd_in  (lkp_opnd),
    .opnd_eff (opnd_eff),
    .mode_out (r_mode),
    .idx_y    (r_y),
    .indirect (r_ind),
    .illegal  (r_ill),
    .len      (r_len)
  );

  pbd_seq #(.OPND_W(OPND_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept),
    .is_pfx  (is_pfx),
    .kind_in (byte_kind),
    .opnd_eff(opnd_eff),
    .cur_kind(cur_kind),
    .opc_fire(opc_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      in_ready     <= 1'b0;
      dec_valid    <= 1'b0;
      dec_opcode   <= '0;
      dec_mode     <= '0;
      dec_idx_y    <= 1'b0;
      dec_indirect <= 1'b0;
      dec_len      <= '0;
      dec_illegal  <= 1'b0;
    end else begin
      in_ready  <= 1'b1;
      dec_valid <= opc_fire;
      if (opc_fire) begin
        dec_opcode   <= in_data;
        dec_mode     <= r_mode;
        dec_idx_y    <= r_y;
        dec_indirect <= r_ind;
        dec_len      <= r_len;
        dec_illegal  <= r_ill;
      end
    end
  end

endmodule

// File: rtl/prebyte_decoder_chk.sv
module prebyte_decoder_chk #(
  parameter int MAX_OPND = 2,
  parameter int LEN_W    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             dec_valid,
  input logic [3:0]       dec_mode,
  input logic             dec_idx_y,
  input logic             dec_indirect,
  input logic [LEN_W-1:0] dec_len,
  input logic             dec_illegal
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !dec_valid && !in_ready);

  assert_pulse_needs_byte_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid && in_ready) |-> !dec_valid);

  assert_len_bound_R11: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (dec_len >= LEN_W'(1)) && (int'(dec_len) <= MAX_OPND + 2));

  assert_indirect_modes_R4: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_indirect) |-> (dec_mode >= 4'd6) && (dec_mode <= 4'd9));

  assert_y_direct_modes_R3: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_idx_y && !dec_indirect) |->
      (dec_mode inside {4'd0, 4'd1, 4'd2, 4'd5}));

  assert_illegal_fallback_R6: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_illegal) |-> !dec_idx_y && !dec_indirect && dec_len >= LEN_W'(2));

endmodule

bind prebyte_decoder prebyte_decoder_chk #(.MAX_OPND(MAX_OPND), .LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .dec_valid   (dec_valid),
  .dec_mode    (dec_mode),
  .dec_idx_y   (dec_idx_y),
  .dec_indirect(dec_indirect),
  .dec_len     (dec_len),
  .dec_illegal (dec_illegal)
);

// File: tb/test_prebyte_decoder.sv
module test_prebyte_decoder;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic [3:0] lkp_mode = 4'd0;
  logic [1:0] lkp_opnd = 2'd0;
  logic       dec_valid;
  logic [7:0] dec_opcode;
  logic [3:0] dec_mode;
  logic       dec_idx_y, dec_indirect, dec_illegal;
  logic [2:0] dec_len;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  prebyte_decoder i_prebyte_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .lkp_mode(lkp_mode), .lkp_opnd(lkp_opnd),
    .dec_valid(dec_valid), .dec_opcode(dec_opcode), .dec_mode(dec_mode),
    .dec_idx_y(dec_idx_y), .dec_indirect(dec_indirect),
    .dec_len(dec_len), .dec_illegal(dec_illegal)
  );

  // {valid, mode, y, ind, len, illegal}
  function automatic logic [10:0] pk(logic v, logic [3:0] m, logic y, logic i,
                                     logic [2:0] l, logic il);
    return {v, m, y, i, l, il};
  endfunction

  function automatic logic [10:0] got();
    return {dec_valid, dec_mode, dec_idx_y, dec_indirect, dec_len, dec_illegal};
  endfunction

  task automatic chk(string req, logic [10:0] g, logic [10:0] e);
    n_chk++;
    if (g !== e) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, g, e);
    end
  endtask

  task automatic chk_idle(string req);
    chk(req, {dec_valid, 10'd0}, 11'd0);
  endtask

  // Offer one byte, return after the edge that accepts it.
  task automatic send(logic [7:0] d, logic [3:0] m, logic [1:0] n);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    lkp_mode = m;
    lkp_opnd = n;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(int cycles);
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 8'h90;
    for (int k = 0; k < cycles; k++) begin
      @(posedge clk);
      #1;
      if (k > 0) chk_idle("R10 idle gap");
    end
  endtask

  // has_pfx, pfx, opcode, base mode, count, exp mode, y, ind, len, illegal
  localparam int NV = 18;
  localparam logic [32:0] VECS [NV] = '{
    {1'b0, 8'h00, 8'hA6, 4'd1,  2'd1, 4'd1,  1'b0, 1'b0, 3'd2, 1'b0}, // R2
    {1'b0, 8'h00, 8'h97, 4'd0,  2'd0, 4'd0,  1'b0, 1'b0, 3'd1, 1'b0}, // R2
    {1'b0, 8'h00, 8'hCC, 4'd10, 2'd2, 4'd10, 1'b0, 1'b0, 3'd3, 1'b0}, // R2
    {1'b1, 8'h90, 8'hAE, 4'd1,  2'd1, 4'd1,  1'b1, 1'b0, 3'd3, 1'b0}, // R3
    {1'b1, 8'h90, 8'hF6, 4'd5,  2'd0, 4'd5,  1'b1, 1'b0, 3'd2, 1'b0}, // R3
    {1'b1, 8'h90, 8'hBE, 4'd2,  2'd1, 4'd2,  1'b1, 1'b0, 3'd3, 1'b0}, // R3
    {1'b1, 8'h90, 8'h93, 4'd0,  2'd0, 4'd0,  1'b1, 1'b0, 3'd2, 1'b0}, // R3
    {1'b1, 8'h92, 8'hBE, 4'd2,  2'd1, 4'd6,  1'b0, 1'b1, 3'd3, 1'b0}, // R4
    {1'b1, 8'h92, 8'h10, 4'd3,  2'd1, 4'd7,  1'b0, 1'b1, 3'd3, 1'b0}, // R4
    {1'b1, 8'h92, 8'h00, 4'd4,  2'd2, 4'd8,  1'b0, 1'b1, 3'd4, 1'b0}, // R4
    {1'b1, 8'h92, 8'hE6, 4'd5,  2'd1, 4'd9,  1'b0, 1'b1, 3'd3, 1'b0}, // R4
    {1'b1, 8'h91, 8'hE6, 4'd5,  2'd1, 4'd9,  1'b1, 1'b1, 3'd3, 1'b0}, // R5
    {1'b1, 8'h91, 8'hBE, 4'd2,  2'd1, 4'd2,  1'b0, 1'b0, 3'd3, 1'b1}, // R6
    {1'b1, 8'h90, 8'h10, 4'd3,  2'd1, 4'd3,  1'b0, 1'b0, 3'd3, 1'b1}, // R6
    {1'b1, 8'h92, 8'hA6, 4'd1,  2'd1, 4'd1,  1'b0, 1'b0, 3'd3, 1'b1}, // R6
    {1'b1, 8'h92, 8'hCC, 4'd10, 2'd2, 4'd10, 1'b0, 1'b0, 3'd4, 1'b1}, // R6
    {1'b0, 8'h00, 8'hD6, 4'd5,  2'd2, 4'd5,  1'b0, 1'b0, 3'd3, 1'b0}, // R8
    {1'b0, 8'h00, 8'h4C, 4'd0,  2'd0, 4'd0,  1'b0, 1'b0, 3'd1, 1'b0}  // R9
  };

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset ready", {10'd0, in_ready}, 11'd0);
    chk_idle("R1 reset valid");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk("R1 ready after reset", {10'd0, in_ready}, 11'd1);

    // Vector table: operand bytes carry prefix values (R8)
    for (int v = 0; v < NV; v++) begin
      logic [32:0] e;
      e = VECS[v];
      if (e[32]) begin
        send(e[31:24], 4'd2, 2'd1);
        chk_idle("R7 prefix gives no pulse");
      end
      send(e[23:16], e[15:12], e[11:10]);
      chk($sformatf("R2-table vector %0d", v), got(),
          pk(1'b1, e[9:6], e[5], e[4], e[3:1], e[0]));
      for (int b = 0; b < int'(e[11:10]); b++) begin
        send(8'h90 + 8'(b), 4'd2, 2'd2);
        chk_idle("R8 operand byte");
      end
    end
    chk("R2 opcode byte", {3'd0, dec_opcode}, {3'd0, 8'h4C});

    // R7: prefix value used as opcode after a prefix
    send(8'h90, 4'd0, 2'd0);
    send(8'h92, 4'd1, 2'd0);
    chk("R7 prefix value as opcode", got(), pk(1'b1, 4'd1, 1'b1, 1'b0, 3'd2, 1'b0));
    // R9: following opcode is unprefixed
    send(8'hA6, 4'd1, 2'd0);
    chk("R9 prefix consumed", got(), pk(1'b1, 4'd1, 1'b0, 1'b0, 3'd1, 1'b0));

    // R9: prefix, opcode with operand, then plain opcode
    send(8'h90, 4'd0, 2'd0);
    send(8'hAE, 4'd1, 2'd1);
    send(8'h00, 4'd0, 2'd0);
    send(8'hAE, 4'd1, 2'd1);
    chk("R9 second instruction", got(), pk(1'b1, 4'd1, 1'b0, 1'b0, 3'd2, 1'b0));
    send(8'h01, 4'd0, 2'd0);

    // R10: prefix held across idle cycles, operand count held too
    send(8'h92, 4'd0, 2'd0);
    idle(5);
    send(8'hBE, 4'd2, 2'd1);
    chk("R10 prefix held", got(), pk(1'b1, 4'd6, 1'b0, 1'b1, 3'd3, 1'b0));
    idle(4);
    send(8'h91, 4'd0, 2'd0);
    chk_idle("R10 operand held");
    send(8'h5F, 4'd0, 2'd0);
    chk("R10 after operand", got(), pk(1'b1, 4'd0, 1'b0, 1'b0, 3'd1, 1'b0));

    // R11: count 3 clamped
    send(8'hCC, 4'd10, 2'd3);
    chk("R11 clamp no prefix", got(), pk(1'b1, 4'd10, 1'b0, 1'b0, 3'd3, 1'b0));
    send(8'h11, 4'd0, 2'd0);
    send(8'h22, 4'd0, 2'd0);
    send(8'h9D, 4'd0, 2'd0);
    chk("R11 two operands only", got(), pk(1'b1, 4'd0, 1'b0, 1'b0, 3'd1, 1'b0));
    send(8'h90, 4'd0, 2'd0);
    send(8'hA6, 4'd1, 2'd3);
    chk("R11 clamp with prefix", got(), pk(1'b1, 4'd1, 1'b1, 1'b0, 3'd4, 1'b0));
    send(8'h33, 4'd0, 2'd0);
    send(8'h44, 4'd0, 2'd0);

    // R1: reset mid-instruction drops pending prefix
    send(8'h92, 4'd0, 2'd0);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk_idle("R1 reset mid-instruction");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    send(8'hBE, 4'd2, 2'd1);
    chk("R1 prefix dropped", got(), pk(1'b1, 4'd2, 1'b0, 1'b0, 3'd2, 1'b0));
    idle(2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R10 watchdog got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule